// File: doc/BRIEF.md
# AXI4 Block Fill-and-Verify Master

This block is an AXI4 full master. On a processor command it fills a fixed region of external memory with a known word pattern. It then reads the region back and compares each word against that pattern. The processor holds a start bit high to request a cycle and keeps it high until it sees the done interrupt. The block therefore starts only on a rising edge of start, and only when it is idle and no interrupt is pending.

Writes go out as sequential 16-beat incrementing bursts of 32-bit words. Each burst waits for its write response before the next address is issued. After the last burst, the same region is read back with the same burst shape. During readback, any error response or protocol slip sets a sticky error flag. Any data difference sets a mismatch flag and captures the index of the first failing word.

When the compare finishes, the interrupt rises and stays high until a rising edge on the clear input. A clear input left high therefore never masks a later interrupt. Each completed cycle advances a seed, so consecutive cycles write different contents.

Top module: `axi_fill_check`

## Requirements
- R1: A rising edge of `start_i` while idle with `irq_o` low begins a cycle: `m_awvalid` rises and the first write address is `BASE` (0x0000_1000).
- R2: A cycle issues exactly `WORDS/BURST` (4) write bursts at addresses `BASE + 64*k`. Each burst has `awlen` = 15, `awsize` = 2 (4 bytes), `awburst` = 1 (INCR) and all `wstrb` bits set, and every address lies inside the region.
- R3: Word `i` (0..63) of cycle `n` is written with the value `i + n`, where `n` counts completed cycles since reset, starting at 0.
- R4: `m_wlast` is high on the 16th beat of every write burst and on no other beat.
- R5: No write or read address is issued while a write burst still awaits its response on the B channel.
- R6: `irq_o` rises when the readback of the last word completes and stays high until a rising edge on `clear_i`.
- R7: A `clear_i` held high does not clear or block a later interrupt. Only a 0-to-1 transition clears.
- R8: `err_o` is set for the rest of the cycle when any B or R response is not OKAY (code 0), or when `m_rlast` disagrees with the beat position. It is cleared by the next accepted start.
- R9: When a read word differs from its expected value, `mismatch_o` is set and `fail_idx_o` holds the index of the first differing word in read order. Both return to 0 on the next accepted start.
- R10: Once raised, `m_awvalid`, `m_wvalid` and `m_arvalid` stay high with stable payload until their ready is seen.
- R11: A start edge that arrives while a cycle is running, or while `irq_o` is high, is ignored and issues no further bursts.
- R12: After reset, `irq_o`, `err_o`, `mismatch_o` and all master valids are low.
- R13: The readback issues exactly 4 read bursts over the same addresses as the writes, after all write responses have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Level start request; rising edge triggers a cycle |
| clear_i | input | 1 | Interrupt clear; rising edge clears |
| irq_o | output | 1 | Sticky done interrupt |
| err_o | output | 1 | Response or protocol error seen this cycle |
| mismatch_o | output | 1 | Readback data differed |
| fail_idx_o | output | 6 | Index of first differing word |
| m_awaddr | output | 32 | Write address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last read beat |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The assertions watch four things on every cycle. They check the handshake rules: each valid is held with a stable payload, `wlast` lands on the 16th beat, and no address is issued while a write response is outstanding. They check that write addresses stay inside the region. They check that the interrupt stays high until a clear edge, and that the master stays silent while the interrupt is pending.

Other properties only the bench scenarios can show, because they depend on the contents of a memory model and on sequences of commands. These are the written pattern and its seed progression, the exact burst and read counts, the error and mismatch flags with the first-failure index, and the dropping of start edges mid-cycle. They also include the rule that a clear held high neither masks nor clears a later interrupt.

// File: rtl/axi_fill_check.sv
module axi_fill_check #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int BURST  = 16,
  parameter logic [ADDR_W-1:0] BASE = 'h1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic                        clear_i,
  output logic                        irq_o,
  output logic                        err_o,
  output logic                        mismatch_o,
  output logic [$clog2(WORDS)-1:0]    fail_idx_o,
  output logic [ADDR_W-1:0]           m_awaddr,
  output logic [7:0]                  m_awlen,
  output logic [2:0]                  m_awsize,
  output logic [1:0]                  m_awburst,
  output logic                        m_awvalid,
  input  logic                        m_awready,
  output logic [DATA_W-1:0]           m_wdata,
  output logic [DATA_W/8-1:0]         m_wstrb,
  output logic                        m_wlast,
  output logic                        m_wvalid,
  input  logic                        m_wready,
  input  logic [1:0]                  m_bresp,
  input  logic                        m_bvalid,
  output logic                        m_bready,
  output logic [ADDR_W-1:0]           m_araddr,
  output logic [7:0]                  m_arlen,
  output logic [2:0]                  m_arsize,
  output logic [1:0]                  m_arburst,
  output logic                        m_arvalid,
  input  logic                        m_arready,
  input  logic [DATA_W-1:0]           m_rdata,
  input  logic [1:0]                  m_rresp,
  input  logic                        m_rlast,
  input  logic                        m_rvalid,
  output logic                        m_rready
);
  localparam int SB  = DATA_W / 8;
  localparam int NB  = WORDS / BURST;
  localparam int BW  = $clog2(BURST);
  localparam int NBW = (NB > 1) ? $clog2(NB) : 1;
  localparam int IW  = $clog2(WORDS);
  localparam int BSH = $clog2(BURST * SB);

  typedef enum logic [2:0] {S_IDLE, S_AW, S_W, S_B, S_AR, S_R} st_t;
  st_t st;

  logic              st_q, cl_q;
  logic [NBW-1:0]    bn;
  logic [BW-1:0]     bt;
  logic [DATA_W-1:0] seed;

  wire start_rise = start_i & ~st_q;
  wire clr_rise   = clear_i & ~cl_q;
  wire last_beat  = bt == BW'(BURST - 1);
  wire last_burst = bn == NBW'(NB - 1);
  wire [NBW+BW-1:0] idx = {bn, bt};
  wire [DATA_W-1:0] pat = seed + DATA_W'(idx);
  wire [ADDR_W-1:0] baddr = BASE + (ADDR_W'(bn) << BSH);

  assign m_awaddr  = baddr;
  assign m_araddr  = baddr;
  assign m_awlen   = 8'(BURST - 1);
  assign m_arlen   = 8'(BURST - 1);
  assign m_awsize  = 3'($clog2(SB));
  assign m_arsize  = 3'($clog2(SB));
  assign m_awburst = 2'b01;
  assign m_arburst = 2'b01;
  assign m_wstrb   = '1;
  assign m_wdata   = pat;
  assign m_wlast   = last_beat;
  assign m_awvalid = st == S_AW;
  assign m_wvalid  = st == S_W;
  assign m_bready  = st == S_B;
  assign m_arvalid = st == S_AR;
  assign m_rready  = st == S_R;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; st_q <= 1'b0; cl_q <= 1'b0;
      bn <= '0; bt <= '0; seed <= '0;
      irq_o <= 1'b0; err_o <= 1'b0; mismatch_o <= 1'b0; fail_idx_o <= '0;
    end else begin
      st_q <= start_i;
      cl_q <= clear_i;
      if (clr_rise) irq_o <= 1'b0;
      case (st)
        S_IDLE: if (start_rise && !irq_o) begin
          err_o <= 1'b0; mismatch_o <= 1'b0; fail_idx_o <= '0;
          bn <= '0; st <= S_AW;
        end
        S_AW: if (m_awready) begin bt <= '0; st <= S_W; end
        S_W: if (m_wready) begin
          bt <= bt + 1'b1;
          if (last_beat) st <= S_B;
        end
        S_B: if (m_bvalid) begin
          if (m_bresp != 2'b00) err_o <= 1'b1;
          if (last_burst) begin bn <= '0; st <= S_AR; end
          else begin bn <= bn + 1'b1; st <= S_AW; end
        end
        S_AR: if (m_arready) begin bt <= '0; st <= S_R; end
        S_R: if (m_rvalid) begin
          if (m_rresp != 2'b00 || m_rlast != last_beat) err_o <= 1'b1;
          if (m_rdata != pat && !mismatch_o) begin
            mismatch_o <= 1'b1;
            fail_idx_o <= IW'(idx);
          end
          bt <= bt + 1'b1;
          if (last_beat) begin
            if (last_burst) begin
              irq_o <= 1'b1; seed <= seed + 1'b1; st <= S_IDLE;
            end else begin
              bn <= bn + 1'b1; st <= S_AR;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/axi_fill_check_sva.sv
module axi_fill_check_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int BURST  = 16,
  parameter logic [ADDR_W-1:0] BASE = 'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_arvalid,
  input logic              m_arready
);
  localparam logic [ADDR_W-1:0] TOP = BASE + ADDR_W'((WORDS - BURST) * (DATA_W / 8));

  logic       cq;
  logic [7:0] wb;
  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cq <= 1'b0; wb <= '0; outst <= '0;
    end else begin
      cq <= clear_i;
      if (m_wvalid && m_wready) wb <= m_wlast ? 8'd0 : wb + 8'd1;
      case ({m_awvalid && m_awready, m_bvalid && m_bready})
        2'b10: outst <= outst + 2'd1;
        2'b01: outst <= outst - 2'd1;
        default: ;
      endcase
    end
  end

  p_aw_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (m_awaddr >= BASE && m_awaddr <= TOP && m_awaddr[1:0] == 2'b00));
  p_wlast_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> (m_wlast == (wb == 8'(BURST - 1))));
  p_aw_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> outst == 2'd0);
  p_ar_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> outst == 2'd0);
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(clear_i && !cq)) |=> irq_o);
  p_aw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
  p_w_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));
  p_ar_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));
  p_quiet_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!m_awvalid && !m_wvalid && !m_arvalid));
endmodule

bind axi_fill_check axi_fill_check_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BURST(BURST), .BASE(BASE)
) u_sva (.*);

// File: tb/tb_axi_fill_check.sv
module tb_axi_fill_check;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start_i, clear_i, irq_o, err_o, mismatch_o;
  logic [5:0] fail_idx_o;
  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [7:0] m_awlen, m_arlen;
  logic [2:0] m_awsize, m_arsize;
  logic [1:0] m_awburst, m_arburst, m_bresp, m_rresp;
  logic [3:0] m_wstrb;
  logic m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
  logic m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;

  axi_fill_check dut (.*);

  logic fast;
  int b_err_burst, r_err_word, bad_a, bad_b;
  logic [31:0] mem [64];
  logic [7:0] lf;
  int wp, rp, rleft;
  logic ract;
  logic [31:0] bcount, aw_cnt, ar_cnt;
  logic [31:0] aw_log [4];
  logic [31:0] ar_log [4];

  assign m_awready = fast | lf[0];
  assign m_wready  = fast | lf[1];
  assign m_arready = fast | lf[2];
  assign m_rvalid  = ract && (fast | lf[3]);
  assign m_rdata   = mem[rp[5:0]] ^ ((rp == bad_a || rp == bad_b) ? 32'h100 : 32'h0);
  assign m_rresp   = (rp == r_err_word) ? 2'b10 : 2'b00;
  assign m_rlast   = rleft == 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lf <= 8'h5A; wp <= 0; rp <= 0; rleft <= 0; ract <= 1'b0;
      m_bvalid <= 1'b0; m_bresp <= 2'b00; bcount <= '0; aw_cnt <= '0; ar_cnt <= '0;
    end else begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (m_awvalid && m_awready) begin
        wp <= int'((m_awaddr - 32'h1000) >> 2);
        aw_log[aw_cnt[1:0]] <= m_awaddr;
        aw_cnt <= aw_cnt + 1;
      end
      if (m_wvalid && m_wready) begin
        mem[wp[5:0]] <= m_wdata;
        wp <= wp + 1;
        if (m_wlast) begin
          m_bvalid <= 1'b1;
          m_bresp <= (int'(bcount[1:0]) == b_err_burst) ? 2'b10 : 2'b00;
          bcount <= bcount + 1;
        end
      end
      if (m_bvalid && m_bready) m_bvalid <= 1'b0;
      if (m_arvalid && m_arready) begin
        rp <= int'((m_araddr - 32'h1000) >> 2);
        rleft <= 16; ract <= 1'b1;
        ar_log[ar_cnt[1:0]] <= m_araddr;
        ar_cnt <= ar_cnt + 1;
      end
      if (m_rvalid && m_rready) begin
        rp <= rp + 1; rleft <= rleft - 1;
        if (rleft == 1) ract <= 1'b0;
      end
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_irq();
    clear_i = 1'b0; tick();
    clear_i = 1'b1; tick(2);
    chk(irq_o == 1'b0, "R6", "irq after clear edge", irq_o, 0);
  endtask

  task automatic run_cycle(input string tag, input int glitch_at,
                           input bit exp_err, input bit exp_mis, input int exp_idx);
    logic [31:0] aw0, ar0;
    int n, bad;
    bit saw;
    start_i = 1'b0; tick();
    aw0 = aw_cnt; ar0 = ar_cnt;
    start_i = 1'b1;
    n = 0; saw = 0;
    while (!irq_o && n < 4000) begin
      tick(); n++;
      if (n == 1) saw = m_awvalid;
      if (glitch_at > 0 && n == glitch_at) start_i = 1'b0;
      if (glitch_at > 0 && n == glitch_at + 1) start_i = 1'b1;
    end
    chk(irq_o == 1'b1, "R6", {tag, " irq raised"}, irq_o, 1);
    chk(saw, "R1", {tag, " awvalid after start edge"}, saw, 1);
    if (glitch_at > 0) tick(40);
    chk(aw_cnt - aw0 == 4, "R2", {tag, " write burst count"}, aw_cnt - aw0, 4);
    chk(ar_cnt - ar0 == 4, "R13", {tag, " read burst count"}, ar_cnt - ar0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(aw_log[k] == 32'h1000 + 32'(64 * k), "R2", {tag, " write addr"}, aw_log[k], 32'h1000 + 64 * k);
      chk(ar_log[k] == 32'h1000 + 32'(64 * k), "R13", {tag, " read addr"}, ar_log[k], 32'h1000 + 64 * k);
    end
    bad = 0;
    for (int k = 0; k < 64; k++) if (mem[k] != 32'(k + cyc)) bad++;
    chk(bad == 0, "R3", {tag, " pattern words wrong"}, bad, 0);
    chk(err_o == exp_err, "R8", {tag, " err flag"}, err_o, exp_err);
    chk(mismatch_o == exp_mis, "R9", {tag, " mismatch flag"}, mismatch_o, exp_mis);
    chk(int'(fail_idx_o) == exp_idx, "R9", {tag, " first fail index"}, fail_idx_o, exp_idx);
    cyc++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int aw0;
    bit saw;
    rst_n = 1'b0; start_i = 1'b0; clear_i = 1'b0; fast = 1'b1;
    b_err_burst = -1; r_err_word = -1; bad_a = -1; bad_b = -1;
    tick(5);
    rst_n = 1'b1; tick();
    chk(!irq_o && !err_o && !mismatch_o, "R12", "flags after reset", {irq_o, err_o, mismatch_o}, 0);
    chk(!m_awvalid && !m_wvalid && !m_arvalid, "R12", "valids after reset",
        {m_awvalid, m_wvalid, m_arvalid}, 0);

    run_cycle("fast", 0, 0, 0, 0);
    tick(30);
    chk(irq_o, "R6", "irq held with no clear", irq_o, 1);
    aw0 = aw_cnt; saw = 0;
    start_i = 1'b0; tick(); start_i = 1'b1;
    for (int i = 0; i < 30; i++) begin tick(); if (m_awvalid) saw = 1; end
    chk(!saw && aw_cnt == aw0, "R11", "start edge while pending", saw, 0);
    chk(irq_o, "R11", "irq still pending", irq_o, 1);
    clear_irq();

    fast = 1'b0;
    run_cycle("stall clear-high", 0, 0, 0, 0);
    tick(20);
    chk(irq_o, "R7", "clear held high does not clear", irq_o, 1);
    clear_irq();

    run_cycle("restart mid-cycle", 25, 0, 0, 0);
    chk(irq_o, "R11", "irq after dropped restart", irq_o, 1);
    clear_irq();

    b_err_burst = 2;
    run_cycle("bresp slverr", 0, 1, 0, 0);
    b_err_burst = -1; clear_irq();

    fast = 1'b1; r_err_word = 5;
    run_cycle("rresp slverr", 0, 1, 0, 0);
    r_err_word = -1; clear_irq();

    for (int m = 0; m < 2; m++) begin
      fast = m[0];
      bad_a = 50; bad_b = 37;
      run_cycle("corrupt 37/50", 0, 0, 1, 37);
      clear_irq();
      bad_a = 63; bad_b = 0;
      run_cycle("corrupt 0/63", 0, 0, 1, 0);
      clear_irq();
      bad_a = 63; bad_b = -1;
      run_cycle("corrupt 63", 0, 0, 1, 63);
      clear_irq();
      bad_a = -1;
      run_cycle("clean after fail", 0, 0, 0, 0);
      clear_irq();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule